// File: doc/BRIEF.md
# Character Display Initialization Sequencer

This block sits on the host side of a dot-matrix character display controller. It is used when the controller's own power-on reset cannot be trusted, because the supply ramp may not meet the conditions that reset needs. After a start pulse the sequencer waits a power-up delay. It then issues the fixed series of instruction writes that forces the controller into a known state. Each write goes to a separate bus-transfer engine through a valid/ready handshake.

The first three writes are 8-bit function-set instructions. The busy flag cannot be read at that point, so a fixed delay paces each step. When the 4-bit path is chosen, a width-switch function set follows as a single upper-nibble transfer. A full function set then carries the interface width, line count and font. Display on/off control, clear and entry-mode set close the sequence. All configuration bits are sampled at the start pulse. When the last delay expires the block raises `done` and stays silent until it receives a new start pulse.

Top module: `chardisp_init_fsm`

## Requirements
- R1: After reset, `done` and `cmd_valid` are both 0, and no write is offered until `start` is pulsed.
- R2: A start pulse is accepted only while the block is idle or done. The first write is offered after exactly PWRUP_CYC+1 cycles with `cmd_valid` low, counted from the start cycle.
- R3: The first three writes carry byte 0x30. After each accepted write, `cmd_valid` stays low for WAIT_FIRST+1, WAIT_SECOND+1 and WAIT_EXEC+1 cycles respectively.
- R4: With `cfg_wide`=1, every write has `cmd_half`=0. The fourth write is the full function set with bit 4 set.
- R5: With `cfg_wide`=0, the first three writes and a fourth write of 0x20 all have `cmd_half`=1, meaning upper nibble only. Every later write has `cmd_half`=0, meaning two nibbles.
- R6: The full function-set byte is 0x20 | wide<<4 | two_line<<3 | tall_font<<2.
- R7: The function set is followed by three writes in order. The first is display control 0x08 | disp<<2 | cursor<<1 | blink. The second is clear 0x01. The third is entry mode 0x04 | inc<<1 | scroll. Each of the function set, display control and clear writes is followed by WAIT_EXEC+1 idle cycles, except the clear, which is followed by WAIT_CLEAR+1 idle cycles.
- R8: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_byte` and `cmd_half` hold their values.
- R9: `done` rises WAIT_EXEC+1 cycles after the entry-mode write is accepted. While `done` is high, no write is offered. A new start pulse clears `done` and reruns the sequence.
- R10: The configuration inputs and any start pulse seen while a sequence runs have no effect on that sequence.
- R11: A configuration of wide=1 with every other bit 0 except inc=1 produces function set 0x30, display control 0x08, clear 0x01 and entry mode 0x06.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that starts a sequence |
| cfg_wide | input | 1 | 1 = 8-bit interface, 0 = 4-bit |
| cfg_two_line | input | 1 | Line-count bit of the function set |
| cfg_tall_font | input | 1 | Font bit of the function set |
| cfg_disp_on | input | 1 | Display-on bit of display control |
| cfg_cursor_on | input | 1 | Cursor bit of display control |
| cfg_blink_on | input | 1 | Blink bit of display control |
| cfg_addr_inc | input | 1 | Increment bit of entry mode |
| cfg_scroll | input | 1 | Display-shift bit of entry mode |
| cmd_valid | output | 1 | A write is offered |
| cmd_ready | input | 1 | The transfer engine accepts the write |
| cmd_byte | output | 8 | Instruction byte |
| cmd_half | output | 1 | 1 = send only the upper nibble as one transfer |
| done | output | 1 | Sequence complete |

## Verification
The bench measures the idle gap before every write. A counter loaded with the wrong table entry, or off by one, would therefore show up as a gap error. It runs the 8-bit path and the 4-bit path. A design that skipped or duplicated the width-switch write, or flagged a post-switch write as a single nibble, would produce the wrong write list. Back-pressure on `cmd_ready` checks that a stalled write keeps its byte. A start pulse and scrambled configuration bits in the middle of a run check that the latched configuration rules. A sequence that restarted or changed its bytes would fail this check. After completion, the bench checks that `done` holds and that no stray write appears.

// File: rtl/chardisp_init_fsm.sv
module chardisp_init_fsm #(
  parameter int PWRUP_CYC   = 50000,
  parameter int WAIT_FIRST  = 20500,
  parameter int WAIT_SECOND = 500,
  parameter int WAIT_EXEC   = 200,
  parameter int WAIT_CLEAR  = 8200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       cfg_wide,
  input  logic       cfg_two_line,
  input  logic       cfg_tall_font,
  input  logic       cfg_disp_on,
  input  logic       cfg_cursor_on,
  input  logic       cfg_blink_on,
  input  logic       cfg_addr_inc,
  input  logic       cfg_scroll,
  output logic       cmd_valid,
  input  logic       cmd_ready,
  output logic [7:0] cmd_byte,
  output logic       cmd_half,
  output logic       done
);

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAXW = max_of(max_of(PWRUP_CYC, WAIT_FIRST),
                               max_of(max_of(WAIT_SECOND, WAIT_EXEC), WAIT_CLEAR));
  localparam int CW = $clog2(MAXW + 1) + 1;

  typedef enum logic [2:0] {IDLE, PWR, ISSUE, HOLD, FIN} st_t;

  st_t            st;
  logic [2:0]     step, nstep;
  logic [7:0]     cfg_q;
  logic [CW-1:0]  cnt, wait_len;
  logic           wide_q;

  assign wide_q = cfg_q[7];

  always_comb begin
    cmd_byte = 8'h30;
    cmd_half = !wide_q;
    wait_len = CW'(WAIT_EXEC);
    case (step)
      3'd0: wait_len = CW'(WAIT_FIRST);
      3'd1: wait_len = CW'(WAIT_SECOND);
      3'd2: ;
      3'd3: begin cmd_byte = 8'h20; cmd_half = 1'b1; end
      3'd4: begin cmd_byte = {3'b001, cfg_q[7:5], 2'b00}; cmd_half = 1'b0; end
      3'd5: begin cmd_byte = {5'b00001, cfg_q[4:2]}; cmd_half = 1'b0; end
      3'd6: begin cmd_byte = 8'h01; cmd_half = 1'b0; wait_len = CW'(WAIT_CLEAR); end
      default: begin cmd_byte = {6'b000001, cfg_q[1:0]}; cmd_half = 1'b0; end
    endcase
  end

  assign nstep     = (step == 3'd2 && wide_q) ? 3'd4 : step + 3'd1;
  assign cmd_valid = (st == ISSUE);
  assign done      = (st == FIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= IDLE;
      cnt   <= '0;
      step  <= '0;
      cfg_q <= '0;
    end else begin
      case (st)
        IDLE, FIN: if (start) begin
          cfg_q <= {cfg_wide, cfg_two_line, cfg_tall_font, cfg_disp_on,
                    cfg_cursor_on, cfg_blink_on, cfg_addr_inc, cfg_scroll};
          cnt   <= CW'(PWRUP_CYC);
          step  <= '0;
          st    <= PWR;
        end
        PWR: if (cnt == '0) st <= ISSUE; else cnt <= cnt - 1'b1;
        ISSUE: if (cmd_ready) begin
          cnt <= wait_len;
          st  <= HOLD;
        end
        HOLD: if (cnt == '0) begin
          if (step == 3'd7) st <= FIN;
          else begin
            step <= nstep;
            st   <= ISSUE;
          end
        end else cnt <= cnt - 1'b1;
        default: st <= IDLE;
      endcase
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_byte) && $stable(cmd_half));

  assert_gap_after_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_valid);

  assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cmd_valid);

  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done && start |=> !done && !cmd_valid);

  assert_start_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start && !cmd_valid && $past(!cmd_valid) |=> !cmd_valid);

endmodule

// File: tb/tb_chardisp_init_fsm.sv
module tb_chardisp_init_fsm;
  localparam int P = 40, W1 = 20, W2 = 9, WE = 5, WC = 14;

  logic clk = 0, rst_n = 0, start = 0, cmd_ready = 1;
  logic [7:0] cfg = 8'h00;
  logic cmd_valid, cmd_half, done;
  logic [7:0] cmd_byte;

  always #4 clk = ~clk;

  chardisp_init_fsm #(.PWRUP_CYC(P), .WAIT_FIRST(W1), .WAIT_SECOND(W2),
                      .WAIT_EXEC(WE), .WAIT_CLEAR(WC)) dut (
    .clk, .rst_n, .start,
    .cfg_wide(cfg[7]), .cfg_two_line(cfg[6]), .cfg_tall_font(cfg[5]),
    .cfg_disp_on(cfg[4]), .cfg_cursor_on(cfg[3]), .cfg_blink_on(cfg[2]),
    .cfg_addr_inc(cfg[1]), .cfg_scroll(cfg[0]),
    .cmd_valid, .cmd_ready, .cmd_byte, .cmd_half, .done);

  int tests = 0, fails = 0;
  bit finished = 0, arm = 0, stall = 0;
  int rcnt = 0;

  logic [7:0] q_byte[$];
  logic       q_half[$];
  int         q_gap[$];
  string      q_req[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b, input logic h, input int g, input string r);
    q_byte.push_back(b); q_half.push_back(h); q_gap.push_back(g); q_req.push_back(r);
  endtask

  always @(posedge clk) begin
    #1;
    rcnt++;
    cmd_ready = stall ? (rcnt % 3 != 0) : 1'b1;
  end

  // monitor / scoreboard
  int gap = 0;
  bit seen = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (start && arm) gap = 0;
      else if (cmd_valid) begin
        if (q_byte.size() == 0) chk(0, "R9 stray write after done", cmd_byte, 0);
        else begin
          if (!seen) begin
            chk(gap == q_gap[0], {q_req[0], " gap"}, gap, q_gap[0]);
            chk(!done, "R9 done low while running", done, 0);
            seen = 1;
          end
          chk(cmd_byte == q_byte[0], {q_req[0], " byte"}, cmd_byte, q_byte[0]);
          chk(cmd_half == q_half[0], {q_req[0], " half"}, cmd_half, q_half[0]);
          if (cmd_ready) begin
            void'(q_byte.pop_front()); void'(q_half.pop_front());
            void'(q_gap.pop_front());  void'(q_req.pop_front());
            gap = 0; seen = 0;
          end
        end
      end else gap++;
    end
  end

  task automatic run(input logic [7:0] c, input bit stl, input bit disturb);
    bit w = c[7];
    push(8'h30, !w, P + 1,  "R2 R3 first write");
    push(8'h30, !w, W1 + 1, "R3 second write");
    push(8'h30, !w, W2 + 1, "R3 third write");
    if (!w) push(8'h20, 1'b1, WE + 1, "R5 width switch");
    push({3'b001, c[7:5], 2'b00}, 1'b0, WE + 1, "R4 R5 R6 function set");
    push({5'b00001, c[4:2]}, 1'b0, WE + 1, "R7 display control");
    push(8'h01, 1'b0, WE + 1, "R7 clear");
    push({6'b000001, c[1:0]}, 1'b0, WC + 1, "R7 entry mode");
    stall = stl;
    @(posedge clk); #2;
    cfg = c; arm = 1; start = 1;
    @(posedge clk); #2;
    start = 0; arm = 0;
    if (disturb) begin
      repeat (60) @(posedge clk);
      #2; cfg = ~c; start = 1;   // R10: ignored while running
      @(posedge clk); #2; start = 0;
    end
    while (q_byte.size() != 0) @(negedge clk);
    repeat (WE + 3) @(negedge clk);
    chk(done == 1'b1, "R9 done after sequence", done, 1);
    repeat (25) @(negedge clk);
    chk(done == 1'b1 && !cmd_valid, "R9 done holds, no write", {done, cmd_valid}, 2);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2; rst_n = 1;
    repeat (5) @(negedge clk);
    chk(!done && !cmd_valid, "R1 reset state idle", {done, cmd_valid}, 0);
    run(8'b1000_0010, 0, 0);            // R11 default-like config
    run(8'b0111_0101, 1, 1);            // R5 4-bit path, stalls, R10 disturb
    run(8'b1101_0111, 1, 0);            // R4 8-bit, other bits
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule